// File: doc/BRIEF.md
# Four-Bit Bidirectional Universal Shift Register

This block holds four bits, `q_o[1]` through `q_o[4]`. A two-bit mode select picks what the register does on each rising clock edge. It can hold its contents, shift toward bit 1 (fed from the high-end serial pin), shift toward bit 4 (fed from the low-end serial pin), or load all four bits in parallel. An active-low clear resets all four bits to zero at once, whatever the clock and mode are doing.

The clock runs freely and drives every flop. Hold works by gating the update enable, not the clock. Because of this, changing the mode select between edges cannot produce an extra register update. Several of these registers can be chained through the serial pins: the bit at each end of `q_o` is the serial output for its direction.

The asynchronous clear is released synchronously. Its release takes effect on the first clock edge after `rst_ni` goes high, and that edge performs no update. The first mode-driven update happens on the second edge after release.

Top module: `univ_shift_reg`

## Requirements
- R1: With mode_i = 2'b00 (mode_i[0] is S0, mode_i[1] is S1), clock edges leave q_o unchanged.
- R2: With mode_i = 2'b10, each edge sets q_o[4] <= ser_hi_i, q_o[3] <= q_o[4], q_o[2] <= q_o[3], q_o[1] <= q_o[2]. q_o[1] is the serial output for this direction.
- R3: With mode_i = 2'b01, each edge sets q_o[1] <= ser_lo_i, q_o[2] <= q_o[1], q_o[3] <= q_o[2], q_o[4] <= q_o[3]. q_o[4] is the serial output for this direction.
- R4: With mode_i = 2'b11, each edge copies par_i[k] into q_o[k] for k = 1..4.
- R5: While rst_ni is low, q_o is 0 immediately, without waiting for a clock edge. This holds in every mode, including load.
- R6: After rst_ni rises, the first clock edge does not update q_o. The mode takes effect from the second edge on.
- R7: q_o changes only on a rising clock edge or on assertion of the clear. Changing mode_i, the serial inputs or par_i between edges has no effect on q_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock, rising edge active |
| rst_ni | input | 1 | Active-low clear: asserted asynchronously, released synchronously |
| mode_i | input | 2 | Mode select; bit 0 is S0, bit 1 is S1 |
| ser_hi_i | input | 1 | Serial input entering at bit 4 (shift toward bit 1) |
| ser_lo_i | input | 1 | Serial input entering at bit 1 (shift toward bit 4) |
| par_i | input | 4 | Parallel load data; par_i[0] is bit 1 |
| q_o | output | 4 | Register contents; q_o[0] is bit 1 |

## Verification
Two functions can fall in the same cycle: a pending parallel load and the clear. The bench provokes this by asserting `rst_ni` low mid-cycle while `mode_i` is 11 and `par_i` is nonzero. It then judges two things:
- `q_o` reads zero before the next edge.
- `q_o` is still zero after that edge.

The other collision is a mode change within a cycle. The bench toggles `mode_i` several times while the clock is low and confirms that `q_o` has not moved. It then confirms that the next edge applies only the mode that is settled at that edge.

// File: rtl/usr_pkg.sv
package usr_pkg;
  localparam int unsigned WIDTH = 4;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_DOWN  = 2'b10,
    MODE_UP    = 2'b01,
    MODE_LOAD  = 2'b11
  } mode_e;
endpackage

// File: rtl/usr_rst_sync.sv
module usr_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic run_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_o <= 1'b0;
    else         run_o <= 1'b1;
  end
endmodule

// File: rtl/usr_next_state.sv
module usr_next_state
  import usr_pkg::*;
#(
  parameter int unsigned W = WIDTH
) (
  input  logic [1:0]   mode_i,
  input  logic         ser_hi_i,
  input  logic         ser_lo_i,
  input  logic [W-1:0] par_i,
  input  logic [W-1:0] q_i,
  output logic         en_o,
  output logic [W-1:0] d_o
);
  logic [W-1:0] up_v, down_v;
  assign up_v   = {q_i[W-2:0], ser_lo_i};
  assign down_v = {ser_hi_i, q_i[W-1:1]};
  assign en_o   = (mode_i != MODE_HOLD);

  for (genvar k = 0; k < W; k++) begin : g_bit
    always_comb begin
      unique case (mode_e'(mode_i))
        MODE_DOWN: d_o[k] = down_v[k];
        MODE_UP:   d_o[k] = up_v[k];
        MODE_LOAD: d_o[k] = par_i[k];
        default:   d_o[k] = q_i[k];
      endcase
    end
  end
endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
  import usr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             ser_hi_i,
  input  logic             ser_lo_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] q_o
);
  logic             run;
  logic             en;
  logic [WIDTH-1:0] d;

  usr_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .run_o(run));

  usr_next_state #(.W(WIDTH)) u_ns (
    .mode_i(mode_i), .ser_hi_i(ser_hi_i), .ser_lo_i(ser_lo_i),
    .par_i(par_i), .q_i(q_o), .en_o(en), .d_o(d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_o <= '0;
    else if (run && en) q_o <= d;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(mode_i) == 2'b00 |-> $stable(q_o)); // R1
  AST_SHIFT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run) && $past(mode_i) == 2'b10 |->
      q_o == {$past(ser_hi_i), $past(q_o[WIDTH-1:1])}); // R2
  AST_SHIFT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run) && $past(mode_i) == 2'b01 |->
      q_o == {$past(q_o[WIDTH-2:0]), $past(ser_lo_i)}); // R3
  AST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run) && $past(mode_i) == 2'b11 |-> q_o == $past(par_i)); // R4
  AST_CLEAR: assert property (@(posedge clk_i) !rst_ni |-> q_o == '0); // R5
  AST_FIRST_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run) |-> q_o == '0); // R6
endmodule

// File: tb/univ_shift_reg_test.sv
module univ_shift_reg_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       ser_hi_i = 1'b0, ser_lo_i = 1'b0;
  logic [3:0] par_i = 4'h0;
  logic [3:0] q_o;
  logic [3:0] model;
  int n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  univ_shift_reg uut (.*);

  task automatic chk(input string req, input logic [3:0] exp);
    n_chk++;
    if (q_o !== exp) begin
      n_fail++;
      $display("FAIL %s: q_o=%b expected=%b", req, q_o, exp);
    end
  endtask

  task automatic edge_mode(input logic [1:0] m);
    mode_i = m;
    @(posedge clk_i); #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; #1;
    chk("R5", 4'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    par_i = 4'hF; mode_i = 2'b11;
    @(posedge clk_i); #1;
    chk("R6", 4'h0);
    model = 4'h0;
  endtask

  task automatic t_load();
    foreach (par_i[i]) ;
    par_i = 4'b1010; edge_mode(2'b11); model = 4'b1010; chk("R4", model);
    par_i = 4'b0111; edge_mode(2'b11); model = 4'b0111; chk("R4", model);
  endtask

  task automatic t_hold();
    par_i = 4'b0000; ser_hi_i = 1'b1; ser_lo_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      edge_mode(2'b00); chk("R1", model);
    end
  endtask

  task automatic t_shift_up();
    logic [7:0] pat = 8'b1011_0010;
    par_i = 4'h0; edge_mode(2'b11); model = 4'h0;
    for (int i = 0; i < 8; i++) begin
      ser_lo_i = pat[i];
      edge_mode(2'b01);
      model = {model[2:0], pat[i]};
      chk("R3", model);
    end
  endtask

  task automatic t_shift_down();
    logic [7:0] pat = 8'b0110_1101;
    par_i = 4'hF; edge_mode(2'b11); model = 4'hF;
    for (int i = 0; i < 8; i++) begin
      ser_hi_i = pat[i];
      edge_mode(2'b10);
      model = {pat[i], model[3:1]};
      chk("R2", model);
    end
  endtask

  task automatic t_toggle();
    par_i = 4'b1001; edge_mode(2'b11); model = 4'b1001;
    @(negedge clk_i);
    mode_i = 2'b01; #0.3; mode_i = 2'b00; #0.3; mode_i = 2'b11; #0.3;
    par_i = 4'b0110; #0.3; mode_i = 2'b10; #0.3; mode_i = 2'b00;
    ser_hi_i = 1'b0; ser_lo_i = 1'b0;
    chk("R7", model);
    @(posedge clk_i); #1;
    chk("R7", model);
    ser_lo_i = 1'b1;
    edge_mode(2'b01); model = {model[2:0], 1'b1}; chk("R7", model);
  endtask

  task automatic t_clear_mid();
    par_i = 4'b1101; edge_mode(2'b11); model = 4'b1101; chk("R4", model);
    @(negedge clk_i);
    par_i = 4'b1111; mode_i = 2'b11; rst_ni = 1'b0; #0.5;
    chk("R5", 4'h0);
    @(posedge clk_i); #1;
    chk("R5", 4'h0);
    do_reset();
  endtask

  initial begin
    fork
      begin
        do_reset();
        t_load();
        t_hold();
        t_shift_up();
        t_shift_down();
        t_toggle();
        t_clear_mid();
        t_load();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: expired expected=finish");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule